// File: doc/BRIEF.md
# Lane Parity Guard

This block sits on a 36-bit data port that is divided into four 9-bit lanes. Each lane carries eight data bits and one parity bit. Every lane of the incoming word is checked against the selected parity sense, and the result is reported per lane and as one combined active-low error flag. Checking is passive: it never alters the word.

A generate enable controls what leaves the block. With generation off, the word passes through untouched. With generation on, each lane's parity bit is replaced with a freshly computed value, and the data bits pass through as they are. One select input chooses odd or even parity, and it applies to checking and generation alike.

The datapath from word to flags is combinational. A parameter chooses whether the combined flag is registered on the port clock, which helps timing, or taken straight from the lane logic.

Top module: `lane_parity_guard`

## Requirements
- R1: The word is four lanes of 9 bits. Lane i occupies bits [9i+8:9i]. Bit 9i+8 is its parity bit and bits [9i+7:9i] are its data bits.
- R2: When `odd_sel_i` is 1, a lane is correct when its nine bits hold an odd number of ones. When it is 0, the count must be even. A change of `odd_sel_i` takes effect in the same cycle.
- R3: `lane_bad_o[i]` is 1 exactly when input lane i fails the selected sense. This holds whether generation is on or off.
- R4: When `gen_en_i` is 0, `port_word_o` equals `port_word_i` bit for bit, even when lanes are in error.
- R5: When `gen_en_i` is 1, every data bit passes through unchanged. Each parity bit is rewritten so that the output lane meets the selected sense, whatever the input parity bit was.
- R6: `perr_n_o` is 0 when at least one lane is in error and 1 when all lanes are correct.
- R7: With `FLAG_REG`=0, `perr_n_o` follows the current inputs in the same cycle. With `FLAG_REG`=1, it shows the inputs sampled at the previous rising edge of `clk`.
- R8: With `FLAG_REG`=1, `perr_n_o` is 1 while `rst_n` is low, whatever the input word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock for the registered flag stage |
| rst_n | input | 1 | Asynchronous active-low reset of the flag stage |
| odd_sel_i | input | 1 | Parity sense: 1 odd, 0 even |
| gen_en_i | input | 1 | 1 rewrites the parity bits on the output |
| port_word_i | input | 36 | Incoming word, four 9-bit lanes |
| port_word_o | output | 36 | Outgoing word |
| lane_bad_o | output | 4 | Per-lane parity mismatch, active high |
| perr_n_o | output | 1 | Combined parity error, active low |

## Verification
The bench instantiates the block twice with the default four lanes of eight data bits. One instance has `FLAG_REG`=1 and the other has `FLAG_REG`=0, so the registered and the direct flag paths are compared against the same expected stream. Both parity senses and both modes are crossed with clean words, all-lanes-corrupt words, single-lane corruption in each position and pseudo-random words. This makes each lane boundary, and the one-cycle offset of the registered flag, observable. Holding reset over a corrupt word shows that the registered flag stays clear while the direct flag still reports the error.

// File: rtl/lpg_pkg.sv
package lpg_pkg;

  typedef enum logic {
    MODE_CHECK = 1'b0,
    MODE_GEN   = 1'b1
  } lpg_mode_e;

  // Parity bit that completes 'bits' to the chosen sense (odd=1 -> odd count).
  function automatic logic parity_of(input logic [63:0] bits, input logic odd);
    return (^bits) ^ odd;
  endfunction

endpackage

// File: rtl/lpg_lane.sv
module lpg_lane #(
  parameter int DW = 8
) (
  input  logic [DW:0] lane_i,
  input  logic        odd_sel_i,
  input  logic        gen_en_i,
  output logic [DW:0] lane_o,
  output logic        bad_o
);
  import lpg_pkg::*;

  logic      calc_par;
  lpg_mode_e mode;

  assign calc_par = parity_of(64'(lane_i[DW-1:0]), odd_sel_i);
  assign bad_o    = lane_i[DW] != calc_par;
  assign mode     = lpg_mode_e'(gen_en_i);

  always_comb begin
    case (mode)
      MODE_GEN: lane_o = {calc_par, lane_i[DW-1:0]};
      default:  lane_o = lane_i;
    endcase
  end

endmodule

// File: rtl/lpg_flag_stage.sv
module lpg_flag_stage #(
  parameter bit REGISTERED = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic any_bad_i,
  output logic flag_n_o
);

  generate
    if (REGISTERED) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_n_o <= 1'b1;
        else        flag_n_o <= ~any_bad_i;
      end
    end else begin : g_comb
      assign flag_n_o = ~any_bad_i;
    end
  endgenerate

endmodule

// File: rtl/lane_parity_guard.sv
module lane_parity_guard #(
  parameter int LANES     = 4,
  parameter int LANE_DATA = 8,
  parameter bit FLAG_REG  = 1'b1,
  localparam int LANE_W   = LANE_DATA + 1,
  localparam int WORD_W   = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              odd_sel_i,
  input  logic              gen_en_i,
  input  logic [WORD_W-1:0] port_word_i,
  output logic [WORD_W-1:0] port_word_o,
  output logic [LANES-1:0]  lane_bad_o,
  output logic              perr_n_o
);

  logic [LANES-1:0] lane_bad;
  logic             any_bad;

  generate
    for (genvar g = 0; g < LANES; g++) begin : g_lane
      lpg_lane #(.DW(LANE_DATA)) u_lane (
        .lane_i    (port_word_i[g*LANE_W +: LANE_W]),
        .odd_sel_i (odd_sel_i),
        .gen_en_i  (gen_en_i),
        .lane_o    (port_word_o[g*LANE_W +: LANE_W]),
        .bad_o     (lane_bad[g])
      );
    end
  endgenerate

  assign any_bad    = |lane_bad;
  assign lane_bad_o = lane_bad;

  lpg_flag_stage #(.REGISTERED(FLAG_REG)) u_flag (
    .clk       (clk),
    .rst_n     (rst_n),
    .any_bad_i (any_bad),
    .flag_n_o  (perr_n_o)
  );

endmodule

// File: rtl/lpg_chk.sv
module lpg_chk #(
  parameter int LANES     = 4,
  parameter int LANE_DATA = 8,
  parameter bit FLAG_REG  = 1'b1,
  localparam int LANE_W   = LANE_DATA + 1,
  localparam int WORD_W   = LANES * LANE_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              odd_sel_i,
  input logic              gen_en_i,
  input logic [WORD_W-1:0] port_word_i,
  input logic [WORD_W-1:0] port_word_o,
  input logic [LANES-1:0]  lane_bad_o,
  input logic              any_bad,
  input logic              perr_n_o
);

  generate
    for (genvar g = 0; g < LANES; g++) begin : g_lane_chk
      // R3
      lane_bad_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lane_bad_o[g] == ((^port_word_i[g*LANE_W +: LANE_W]) != odd_sel_i));
      // R5
      gen_sense_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gen_en_i |-> ((^port_word_o[g*LANE_W +: LANE_W]) == odd_sel_i));
      // R5
      gen_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        port_word_o[g*LANE_W +: LANE_DATA] == port_word_i[g*LANE_W +: LANE_DATA]);
    end
  endgenerate

  // R4
  check_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !gen_en_i |-> (port_word_o == port_word_i));

  generate
    if (FLAG_REG) begin : g_reg_chk
      // R7
      flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(lane_bad_o) != 0) |=> !perr_n_o);
      // R6
      flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !any_bad |=> perr_n_o);
      // R8
      always @(negedge clk) begin
        if (rst_n === 1'b0) begin
          reset_flag_chk: assert (perr_n_o === 1'b1);
        end
      end
    end else begin : g_comb_chk
      // R6
      flag_now_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(lane_bad_o) == 0) == perr_n_o);
    end
  endgenerate

endmodule

bind lane_parity_guard lpg_chk #(
  .LANES     (LANES),
  .LANE_DATA (LANE_DATA),
  .FLAG_REG  (FLAG_REG)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .odd_sel_i   (odd_sel_i),
  .gen_en_i    (gen_en_i),
  .port_word_i (port_word_i),
  .port_word_o (port_word_o),
  .lane_bad_o  (lane_bad_o),
  .any_bad     (any_bad),
  .perr_n_o    (perr_n_o)
);

// File: tb/lane_parity_guard_bench.sv
module lane_parity_guard_bench;

  localparam int CLK_NS = 20;
  localparam int W      = 36;

  typedef struct {
    logic [W-1:0] exp_w;
    logic [3:0]   exp_bad;
    logic         exp_flag_n;
    logic         gen;
  } item_t;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         odd_sel = 1'b0;
  logic         gen_en = 1'b0;
  logic [W-1:0] word_i = '0;
  logic [W-1:0] word_o_r, word_o_c;
  logic [3:0]   bad_r, bad_c;
  logic         flag_r, flag_c;

  int    n_checks = 0;
  int    n_fails = 0;
  bit    done = 1'b0;
  item_t q[$];
  logic [31:0] lfsr = 32'h1D2C_3B4A;

  always #(CLK_NS/2) clk = ~clk;

  lane_parity_guard #(.FLAG_REG(1'b1)) u_lane_parity_guard (
    .clk(clk), .rst_n(rst_n), .odd_sel_i(odd_sel), .gen_en_i(gen_en),
    .port_word_i(word_i), .port_word_o(word_o_r), .lane_bad_o(bad_r),
    .perr_n_o(flag_r));

  lane_parity_guard #(.FLAG_REG(1'b0)) u_lane_parity_guard_comb (
    .clk(clk), .rst_n(rst_n), .odd_sel_i(odd_sel), .gen_en_i(gen_en),
    .port_word_i(word_i), .port_word_o(word_o_c), .lane_bad_o(bad_c),
    .perr_n_o(flag_c));

  function automatic int ones8(input logic [7:0] v);
    int c = 0;
    for (int i = 0; i < 8; i++) if (v[i]) c++;
    return c;
  endfunction

  // R1: lane l data in [9l+7:9l], parity in bit 9l+8. Builds a word that is
  // correct for the sense, then flips the parity bit of lanes in 'corrupt'.
  function automatic logic [W-1:0] make_word(input logic [31:0] data, input logic odd,
                                             input logic [3:0] corrupt);
    logic [W-1:0] w;
    for (int l = 0; l < 4; l++) begin
      logic [7:0] d;
      d = data[8*l +: 8];
      w[9*l +: 8] = d;
      w[9*l + 8]  = ((ones8(d) % 2) != int'(odd)) ^ corrupt[l];
    end
    return w;
  endfunction

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Driver: applies one word and pushes what the outputs must show.
  task automatic drive(input logic [W-1:0] w, input logic odd, input logic gen);
    item_t it;
    @(negedge clk);
    word_i  = w;
    odd_sel = odd;
    gen_en  = gen;
    it.gen = gen;
    it.exp_w = w;
    for (int l = 0; l < 4; l++) begin
      int c;
      c = ones8(w[9*l +: 8]) + int'(w[9*l + 8]);
      it.exp_bad[l] = (c % 2) != int'(odd);   // R2 sense, R3 flag
      if (gen) it.exp_w[9*l + 8] = (ones8(w[9*l +: 8]) % 2) != int'(odd);
    end
    it.exp_flag_n = (it.exp_bad == 4'b0);
    q.push_back(it);
  endtask

  // Monitor: outputs of the word applied at the previous falling edge,
  // registered flag sampled after the rising edge that captured it.
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        check(it.gen ? "R5 word (reg inst)" : "R4 word (reg inst)", word_o_r, it.exp_w);
        check(it.gen ? "R5 word (comb inst)" : "R4 word (comb inst)", word_o_c, it.exp_w);
        check("R1 R2 R3 lane_bad", W'(bad_r), W'(it.exp_bad));
        check("R3 lane_bad (comb inst)", W'(bad_c), W'(it.exp_bad));
        check("R6 R7 registered flag", W'(flag_r), W'(it.exp_flag_n));
        check("R6 R7 direct flag", W'(flag_c), W'(it.exp_flag_n));
      end
    end
  end

  initial begin
    // R8: reset held over a corrupt word
    word_i = make_word(32'h0000_0000, 1'b0, 4'b0101);
    repeat (2) @(posedge clk);
    #5;
    check("R8 flag in reset", W'(flag_r), W'(1'b1));
    check("R7 direct flag ignores reset", W'(flag_c), W'(1'b0));
    @(negedge clk);
    rst_n = 1'b1;

    for (int o = 0; o < 2; o++) begin
      for (int g = 0; g < 2; g++) begin
        drive(make_word(32'h0, o[0], 4'h0), o[0], g[0]);
        drive(make_word(32'h0, o[0], 4'hF), o[0], g[0]);
        drive(make_word(32'hFFFF_FFFF, o[0], 4'h0), o[0], g[0]);
        for (int l = 0; l < 4; l++)
          drive(make_word(32'hA5C3_5A3C, o[0], 4'(1 << l)), o[0], g[0]);
        for (int k = 0; k < 6; k++) begin
          lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
          drive(make_word(lfsr, o[0], lfsr[7:4] & lfsr[3:0]), o[0], g[0]);
        end
      end
    end
    // R2: same word seen under both senses back to back
    drive(make_word(32'h1234_5678, 1'b1, 4'h0), 1'b1, 1'b0);
    drive(make_word(32'h1234_5678, 1'b1, 4'h0), 1'b0, 1'b0);
    drive(make_word(32'h1234_5678, 1'b1, 4'h0), 1'b0, 1'b1);

    wait (q.size() == 0);
    @(posedge clk);
    #6;
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    #(CLK_NS * 20000);
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog R1..all actual=hung expected=completed");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end

endmodule